// File: doc/BRIEF.md
# Chip Erase Polling Sequencer

This block drives a whole-device flash erase through a debug transaction master and reports how it ended. A start pulse begins a sequence. The sequencer can first read the chip identity to confirm that the target answers in debug mode. It then sends the erase command and takes the status byte that comes back with it. While bit 7 of the status reads busy, it waits a programmable number of time-base ticks and sends a status-read command, and it repeats this until the busy bit clears.

An overall watchdog counted in time-base ticks limits the whole sequence. With a 1 kHz tick, the default limit is three seconds. If the limit runs out, or the transaction master reports that it gave up waiting for an answer, the sequence ends with the timeout flag set. The serial bit timing, the wait cycle after each command and bringing the target into debug mode all belong to the transaction master and its controller.

Top module: `erase_poll_seq`

## Requirements
- R1: After reset, done, ok and tmo are low, last_status is 0x00 and txn_req is low.
- R2: With CHECK_ID_FIRST set, the first command after an accepted start is ID_CMD (default 0x68). The erase command follows only after the identity response arrives.
- R3: The erase command byte is the ERASE_CMD parameter. Bit 2 is don't-care, so 0x10 and 0x14 are both legal, and every erase byte sent satisfies (byte & 0xFB) == 0x10.
- R4: A status byte with bit 7 set means busy and leads to a poll with command 0x34. A byte with bit 7 clear (for example 0x22 after 0xA2 responses) ends the sequence with ok high.
- R5: After a busy response, the next poll request goes out exactly poll_gap+2 clock cycles later when tick is high every cycle. In general it waits poll_gap ticks.
- R6: If no completing response has been accepted by the edge that falls TIMEOUT_TICKS+1 ticks after the start edge, the sequence ends at that edge with tmo high and ok low. A completing response accepted at that same edge wins and gives ok.
- R7: A response timeout from the transaction master (txn_rsp_tmo) during any wait ends the sequence with tmo high and ok low.
- R8: done is high for exactly one cycle per sequence. ok and tmo are never high together, and both hold their values until the next accepted start.
- R9: A start pulse while a sequence is active is ignored: no extra command is issued and no extra done pulse appears.
- R10: last_status is cleared at an accepted start and then holds the most recent erase or poll response byte. Identity responses do not change it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | Time-base clock enable for the gap and the watchdog |
| start | input | 1 | Begin a sequence (taken only when idle) |
| poll_gap | input | GAP_W | Ticks to wait between a busy response and the next poll |
| txn_req | output | 1 | One-cycle command request to the transaction master |
| txn_cmd | output | 8 | Command byte presented with txn_req |
| txn_rsp_valid | input | 1 | Response byte is valid this cycle |
| txn_rsp_byte | input | 8 | Response byte from the target |
| txn_rsp_tmo | input | 1 | Transaction master gave up waiting for a response |
| done | output | 1 | One-cycle end-of-sequence pulse |
| ok | output | 1 | Erase completed (held) |
| tmo | output | 1 | Sequence ended by a timeout (held) |
| last_status | output | 8 | Latest erase or poll status byte |

## Verification
A completing status response and the expiry of the overall watchdog can fall on the same clock edge. The bench provokes this by making the model master hold the erase response until a cycle computed from the start edge and the tick limit. In one run the clear status byte lands exactly on the expiry edge, and the result must be ok. In the other run it lands one edge later, and the result must be a timeout, with done arriving on the expiry edge itself.

// File: rtl/erase_poll_pkg.sv
package erase_poll_pkg;

    typedef enum logic [2:0] {
        S_IDLE,
        S_ID_REQ,
        S_ID_WAIT,
        S_ERASE_REQ,
        S_POLL_REQ,
        S_ST_WAIT,
        S_GAP,
        S_DONE
    } seq_state_e;

    typedef struct packed {
        logic ok;
        logic tmo;
    } seq_result_t;

    typedef struct packed {
        logic done_clear;
        logic busy;
        logic link_fail;
    } rsp_class_t;

    localparam logic [7:0] POLL_STATUS_CMD = 8'h34;
    localparam logic [7:0] ERASE_CLASS     = 8'h10;
    localparam logic [7:0] ERASE_DC_MASK   = 8'hFB;
    localparam int         BUSY_BIT        = 7;

    function automatic logic status_busy(input logic [7:0] b);
        return b[BUSY_BIT];
    endfunction

    function automatic logic erase_cmd_legal(input logic [7:0] b);
        return (b & ERASE_DC_MASK) == ERASE_CLASS;
    endfunction

    function automatic logic state_active(input seq_state_e s);
        return (s != S_IDLE) && (s != S_DONE);
    endfunction

endpackage

// File: rtl/erase_tick_down.sv
module erase_tick_down #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         tick,
    output logic         zero
);

    logic [W-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt_q <= '0;
        end else if (load) begin
            cnt_q <= load_val;
        end else if (tick && (cnt_q != '0)) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign zero = (cnt_q == '0);

    // R6
    zero_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (zero && !load) |=> zero);

endmodule

// File: rtl/erase_status_decode.sv
module erase_status_decode
    import erase_poll_pkg::*;
(
    input  logic       in_wait,
    input  logic       rsp_valid,
    input  logic       rsp_tmo,
    input  logic [7:0] rsp_byte,
    output rsp_class_t cls
);

    always_comb begin
        cls = '0;
        if (in_wait) begin
            if (rsp_tmo) begin
                cls.link_fail = 1'b1;
            end else if (rsp_valid) begin
                cls.busy       = status_busy(rsp_byte);
                cls.done_clear = !status_busy(rsp_byte);
            end
        end
    end

endmodule

// File: rtl/erase_poll_seq.sv
module erase_poll_seq
    import erase_poll_pkg::*;
#(
    parameter int         GAP_W          = 8,
    parameter int         TIMEOUT_TICKS  = 3000,
    parameter logic [7:0] ERASE_CMD      = 8'h10,
    parameter logic [7:0] ID_CMD         = 8'h68,
    parameter bit         CHECK_ID_FIRST = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             start,
    input  logic [GAP_W-1:0] poll_gap,
    output logic             txn_req,
    output logic [7:0]       txn_cmd,
    input  logic             txn_rsp_valid,
    input  logic [7:0]       txn_rsp_byte,
    input  logic             txn_rsp_tmo,
    output logic             done,
    output logic             ok,
    output logic             tmo,
    output logic [7:0]       last_status
);

    localparam int TMO_W = $clog2(TIMEOUT_TICKS + 1);
    localparam logic [TMO_W-1:0] TMO_LOAD = TMO_W'(TIMEOUT_TICKS);

    seq_state_e  state_q, state_d;
    seq_result_t res_q, res_d;
    logic [7:0]  status_q, status_d;
    logic        accept_start;
    logic        expired;
    logic        gap_zero;
    logic        gap_load;
    rsp_class_t  id_cls, st_cls;

    assign accept_start = (state_q == S_IDLE) && start;

    erase_tick_down #(.W(TMO_W)) watchdog_i (
        .clk      (clk),
        .rst      (rst),
        .load     (accept_start),
        .load_val (TMO_LOAD),
        .tick     (tick),
        .zero     (expired)
    );

    erase_tick_down #(.W(GAP_W)) gap_i (
        .clk      (clk),
        .rst      (rst),
        .load     (gap_load),
        .load_val (poll_gap),
        .tick     (tick),
        .zero     (gap_zero)
    );

    erase_status_decode id_dec_i (
        .in_wait   (state_q == S_ID_WAIT),
        .rsp_valid (txn_rsp_valid),
        .rsp_tmo   (txn_rsp_tmo),
        .rsp_byte  (txn_rsp_byte),
        .cls       (id_cls)
    );

    erase_status_decode st_dec_i (
        .in_wait   (state_q == S_ST_WAIT),
        .rsp_valid (txn_rsp_valid),
        .rsp_tmo   (txn_rsp_tmo),
        .rsp_byte  (txn_rsp_byte),
        .cls       (st_cls)
    );

    always_comb begin
        state_d  = state_q;
        res_d    = res_q;
        status_d = status_q;
        gap_load = 1'b0;
        unique case (state_q)
            S_IDLE: begin
                if (start) begin
                    res_d    = '0;
                    status_d = 8'h00;
                    state_d  = CHECK_ID_FIRST ? S_ID_REQ : S_ERASE_REQ;
                end
            end
            S_ID_REQ: begin
                state_d = expired ? S_DONE : S_ID_WAIT;
                if (expired) res_d = '{ok: 1'b0, tmo: 1'b1};
            end
            S_ID_WAIT: begin
                if (id_cls.link_fail || expired) begin
                    state_d = S_DONE;
                    res_d   = '{ok: 1'b0, tmo: 1'b1};
                end else if (txn_rsp_valid) begin
                    state_d = S_ERASE_REQ;
                end
            end
            S_ERASE_REQ, S_POLL_REQ: begin
                state_d = expired ? S_DONE : S_ST_WAIT;
                if (expired) res_d = '{ok: 1'b0, tmo: 1'b1};
            end
            S_ST_WAIT: begin
                if (st_cls.link_fail) begin
                    state_d = S_DONE;
                    res_d   = '{ok: 1'b0, tmo: 1'b1};
                end else if (st_cls.done_clear) begin
                    status_d = txn_rsp_byte;
                    state_d  = S_DONE;
                    res_d    = '{ok: 1'b1, tmo: 1'b0};
                end else if (st_cls.busy) begin
                    status_d = txn_rsp_byte;
                    if (expired) begin
                        state_d = S_DONE;
                        res_d   = '{ok: 1'b0, tmo: 1'b1};
                    end else begin
                        gap_load = 1'b1;
                        state_d  = S_GAP;
                    end
                end else if (expired) begin
                    state_d = S_DONE;
                    res_d   = '{ok: 1'b0, tmo: 1'b1};
                end
            end
            S_GAP: begin
                if (expired) begin
                    state_d = S_DONE;
                    res_d   = '{ok: 1'b0, tmo: 1'b1};
                end else if (gap_zero) begin
                    state_d = S_POLL_REQ;
                end
            end
            S_DONE: state_d = S_IDLE;
            default: state_d = S_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q  <= S_IDLE;
            res_q    <= '0;
            status_q <= 8'h00;
        end else begin
            state_q  <= state_d;
            res_q    <= res_d;
            status_q <= status_d;
        end
    end

    always_comb begin
        txn_req = 1'b0;
        txn_cmd = 8'h00;
        case (state_q)
            S_ID_REQ:    begin txn_req = 1'b1; txn_cmd = ID_CMD;          end
            S_ERASE_REQ: begin txn_req = 1'b1; txn_cmd = ERASE_CMD;       end
            S_POLL_REQ:  begin txn_req = 1'b1; txn_cmd = POLL_STATUS_CMD; end
            default:     begin txn_req = 1'b0; txn_cmd = 8'h00;           end
        endcase
    end

    assign done        = (state_q == S_DONE);
    assign ok          = res_q.ok;
    assign tmo         = res_q.tmo;
    assign last_status = status_q;

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    flags_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(ok && tmo));

    // R8
    done_result_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (ok ^ tmo));

    // R4
    ok_status_chk: assert property (@(posedge clk) disable iff (rst)
        (done && ok) |-> !last_status[BUSY_BIT]);

    // R3
    erase_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        (txn_req && state_q == S_ERASE_REQ) |-> erase_cmd_legal(txn_cmd));

    // R5
    gap_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (state_q == S_GAP && !gap_zero) |=> !txn_req);

    // R7
    link_fail_chk: assert property (@(posedge clk) disable iff (rst)
        ((state_q == S_ST_WAIT || state_q == S_ID_WAIT) && txn_rsp_tmo) |=> (done && tmo));

    // R6
    expiry_chk: assert property (@(posedge clk) disable iff (rst)
        (state_active(state_q) && expired && !st_cls.done_clear) |=> (done && tmo));

endmodule

// File: tb/erase_poll_seq_tb_top.sv
module erase_poll_seq_tb_top;

    localparam int         GAP_W  = 8;
    localparam int         TMO_T  = 60;
    localparam logic [7:0] ER_CMD = 8'h14;
    localparam logic [7:0] ID_C   = 8'h68;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             tick = 1'b0;
    logic             start = 1'b0;
    logic [GAP_W-1:0] poll_gap = '0;
    logic             txn_req;
    logic [7:0]       txn_cmd;
    logic             txn_rsp_valid;
    logic [7:0]       txn_rsp_byte;
    logic             txn_rsp_tmo;
    logic             done, ok, tmo;
    logic [7:0]       last_status;

    erase_poll_seq #(
        .GAP_W(GAP_W), .TIMEOUT_TICKS(TMO_T), .ERASE_CMD(ER_CMD),
        .ID_CMD(ID_C), .CHECK_ID_FIRST(1'b1)
    ) dut_i (
        .clk(clk), .rst(rst), .tick(tick), .start(start), .poll_gap(poll_gap),
        .txn_req(txn_req), .txn_cmd(txn_cmd), .txn_rsp_valid(txn_rsp_valid),
        .txn_rsp_byte(txn_rsp_byte), .txn_rsp_tmo(txn_rsp_tmo),
        .done(done), .ok(ok), .tmo(tmo), .last_status(last_status)
    );

    always #2 clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 1'b0;

    logic [7:0] cmd_log [0:63];
    int diff_log [0:63];
    int req_n = 0;
    int busy_n = 0;
    int resp_idx = 0;
    int mode = 0;
    int tie_drive = 0;
    int last_rsp_cyc = 0;
    int s_cyc = 0;
    int done_cyc = 0;
    int done_cnt = 0;

    always @(negedge clk) if (done) done_cnt <= done_cnt + 1;

    // model transaction master
    initial begin
        txn_rsp_valid = 1'b0;
        txn_rsp_tmo   = 1'b0;
        txn_rsp_byte  = 8'h00;
        forever begin
            @(negedge clk);
            txn_rsp_valid = 1'b0;
            txn_rsp_tmo   = 1'b0;
            if (txn_req) begin
                if (req_n < 64) begin
                    cmd_log[req_n]  = txn_cmd;
                    diff_log[req_n] = cyc - last_rsp_cyc;
                end
                req_n++;
                if (txn_cmd == ID_C) begin
                    @(negedge clk);
                    txn_rsp_byte  = 8'hA5;
                    txn_rsp_valid = 1'b1;
                end else if (mode == 1) begin
                    repeat (2) @(negedge clk);
                    txn_rsp_tmo = 1'b1;
                end else if (mode == 2) begin
                    while (cyc < tie_drive) @(negedge clk);
                    txn_rsp_byte  = 8'h22;
                    txn_rsp_valid = 1'b1;
                    last_rsp_cyc  = cyc;
                end else begin
                    repeat (2) @(negedge clk);
                    txn_rsp_byte  = (resp_idx < busy_n) ? 8'hA2 : 8'h22;
                    resp_idx++;
                    txn_rsp_valid = 1'b1;
                    last_rsp_cyc  = cyc;
                end
            end
        end
    end

    task automatic chk(input bit cond, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (!cond) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    task automatic prep(input int m, input int bn, input int g);
        mode = m; busy_n = bn; resp_idx = 0; req_n = 0;
        poll_gap = GAP_W'(g); done_cnt = 0;
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        s_cyc = cyc + 1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic wait_done();
        int lim = 0;
        while (!done && lim < 2000) begin
            @(negedge clk);
            lim++;
        end
        done_cyc = cyc;
        chk(done == 1'b1, "R8 done seen", done, 1);
    endtask

    task automatic t_reset();
        chk(done == 0 && ok == 0 && tmo == 0, "R1 flags after reset", {done, ok, tmo}, 0);
        chk(last_status == 8'h00, "R1 status after reset", last_status, 0);
        chk(txn_req == 0, "R1 no request after reset", txn_req, 0);
    endtask

    task automatic t_quick();
        prep(0, 0, 3);
        pulse_start();
        wait_done();
        chk(ok == 1 && tmo == 0, "R4 clear status gives ok", {ok, tmo}, 2);
        chk(last_status == 8'h22, "R10 status after quick", last_status, 8'h22);
        repeat (6) @(negedge clk);
        chk(req_n == 2, "R2 request count quick", req_n, 2);
        chk(cmd_log[0] == ID_C, "R2 identity first", cmd_log[0], ID_C);
        chk((cmd_log[1] & 8'hFB) == 8'h10 && cmd_log[1] == ER_CMD, "R3 erase byte", cmd_log[1], ER_CMD);
        chk(done_cnt == 1, "R8 one done pulse", done_cnt, 1);
        chk(ok == 1 && done == 0, "R8 ok held after done", {ok, done}, 2);
    endtask

    task automatic t_polls();
        prep(0, 3, 5);
        pulse_start();
        repeat (10) @(negedge clk);
        pulse_start();
        wait_done();
        chk(ok == 1 && tmo == 0, "R4 ok after busy polls", {ok, tmo}, 2);
        chk(last_status == 8'h22, "R10 final status", last_status, 8'h22);
        repeat (6) @(negedge clk);
        chk(req_n == 5, "R9 no extra commands", req_n, 5);
        chk(done_cnt == 1, "R9 single done despite extra start", done_cnt, 1);
        for (int i = 2; i < 5; i++) begin
            chk(cmd_log[i] == 8'h34, "R4 poll byte", cmd_log[i], 8'h34);
            chk(diff_log[i] == 5 + 2, "R5 poll spacing", diff_log[i], 7);
        end
    endtask

    task automatic t_overall_tmo();
        prep(0, 100000, 2);
        pulse_start();
        wait_done();
        chk(tmo == 1 && ok == 0, "R6 watchdog timeout", {ok, tmo}, 1);
        chk(done_cyc == s_cyc + TMO_T + 1, "R6 expiry edge", done_cyc, s_cyc + TMO_T + 1);
        chk(last_status == 8'hA2, "R10 busy status kept", last_status, 8'hA2);
        repeat (8) @(negedge clk);
        chk(done_cnt == 1, "R8 one done on timeout", done_cnt, 1);
    endtask

    task automatic t_tie(input int off, input bit exp_ok);
        prep(2, 0, 1);
        pulse_start();
        tie_drive = s_cyc + TMO_T + off;
        wait_done();
        if (exp_ok) begin
            chk(ok == 1 && tmo == 0, "R6 completion on expiry edge wins", {ok, tmo}, 2);
        end else begin
            chk(ok == 0 && tmo == 1, "R6 completion after expiry loses", {ok, tmo}, 1);
            chk(done_cyc == s_cyc + TMO_T + 1, "R6 late expiry edge", done_cyc, s_cyc + TMO_T + 1);
        end
        repeat (8) @(negedge clk);
    endtask

    task automatic t_master_tmo();
        prep(1, 0, 1);
        pulse_start();
        wait_done();
        chk(tmo == 1 && ok == 0, "R7 master timeout", {ok, tmo}, 1);
        chk(done_cyc < s_cyc + 20, "R7 ends promptly", done_cyc, s_cyc);
        chk(last_status == 8'h00, "R10 cleared at start", last_status, 0);
        repeat (6) @(negedge clk);
        chk(tmo == 1 && done == 0, "R8 tmo held", {tmo, done}, 2);
    endtask

    task automatic t_restart();
        prep(0, 1, 0);
        pulse_start();
        @(negedge clk);
        chk(tmo == 0, "R8 flags cleared at new start", tmo, 0);
        wait_done();
        chk(ok == 1 && tmo == 0, "R4 ok after one busy", {ok, tmo}, 2);
        repeat (6) @(negedge clk);
        chk(req_n == 3, "R5 zero gap poll count", req_n, 3);
        chk(diff_log[2] == 2, "R5 zero gap spacing", diff_log[2], 2);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        n_chk++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        repeat (4) @(negedge clk);
        rst  = 1'b0;
        tick = 1'b1;
        @(negedge clk);
        t_reset();
        t_quick();
        t_polls();
        t_overall_tmo();
        t_tie(0, 1'b1);
        t_tie(1, 1'b0);
        t_master_tmo();
        t_restart();
        summary();
    end

endmodule